// File: doc/BRIEF.md
# Dual-Channel Compare-Clear Timer

This block holds two independent 16-bit up-counters. Each one advances on a shared prescaled count-enable pulse, but only while its own run bit is set. Every channel has four compare registers, named A to D. A control field can choose one of A, B or C as the clearing source. When a clearing source is chosen, the counter wraps to zero on a match with that register, so the channel runs as a periodic counter. When no clearing source is chosen, the channel runs free and sets an overflow flag each time it wraps past 0xFFFF.

Every compare register sets its own match flag. Each flag has its own enable bit. A channel raises its interrupt line while any enabled flag is set. Software clears a flag in two steps: it reads the flag as 1, then writes 0 to it. If an event sets a flag in the same cycle as the clearing write, the set takes effect and the clear does not.

Software reaches all state through a simple register bus. A write takes effect on the clock edge. A read returns data combinationally during the same cycle as the read strobe.

Top module: `cct_timer`

## Requirements
- R1: After a synchronous reset, the following hold. Every counter, control field, status flag, enable bit and run bit is 0. Every compare register holds 0xFFFF. Both interrupt lines are low.
- R2: A channel's counter increases by one on each clock edge where `cnt_en` is 1 and the channel's run bit is 1. The run bits sit at address 0: bit 0 is channel 0 and bit 1 is channel 1. A channel that is stopped holds its value, and each channel counts independently of the other.
- R3: Suppose the counter is 0xFFFF, a count occurs, and no clearing match happens. The counter then becomes 0x0000 and the overflow flag is set. The overflow flag is status bit 4.
- R4: The clear-select field is bits [1:0] of the channel control register. Its codes are 00 for no clearing, 01 for register A, 10 for register B and 11 for register C. If a count occurs while the counter equals the selected register, the counter loads 0 instead of incrementing.
- R5: If a count occurs while the counter equals compare register X, the match flag for X is set, whatever the clear select holds. The match flags are status bits 0 to 3 for A to D. Without a count, no match flag is set.
- R6: A match on register D sets its flag but never clears the counter. The counter keeps incrementing.
- R7: If a clearing match happens at 0xFFFF, the counter becomes 0 and the overflow flag is not set.
- R8: A write of 0 to a flag clears it only if the flag was read as 1 since the last status write. Writing 1 to a flag leaves it unchanged. Writing 0 to a flag that was not read first leaves it unchanged.
- R9: If a flag-setting event and a clearing write to that flag happen in the same cycle, the flag stays set.
- R10: A channel's interrupt line is high while some status flag and its enable bit are both 1. The enable register uses the same bit positions as the status register. The line stays high until the flag or the enable is cleared.
- R11: Software can write the counter. A write takes priority over a count in the same cycle.
- R12: The register map works as follows. Address bits [4:3] select the bank: 0 is global, 1 is channel 0 and 2 is channel 1. Within a channel bank, bits [2:0] select the register: 0 control, 1 enable, 2 status, 3 counter, 4 to 7 compare A to D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| cnt_en | input | 1 | Prescaled count-enable pulse |
| irq | output | 2 | Interrupt request, one per channel |

## Verification
Internal faults in this block cannot stay hidden for long. A wrong counter step or a wrong clear decision shows up in the counter value that software reads, starting on the first count after the fault. A wrong flag or arming state appears at the status read or on the interrupt line in the cycle after the event. A flag that is cleared too early, or not cleared, shows up as `irq` changing too soon or staying high after a proper clear sequence. The bench therefore tests each clear source and each boundary value in turn: 0xFFFF, a match on register D, and a set in the same cycle as a clear. It checks both the counter and the interrupt line at each step.

// File: rtl/cct_pkg.sv
// Shared constants and types for the dual-channel compare-clear timer.
package cct_pkg;
    localparam int CMP_N     = 4;              // compare registers per channel
    localparam int FLAG_N    = CMP_N + 1;      // match flags plus overflow
    localparam int OVF_BIT   = CMP_N;          // overflow flag position
    localparam int REG_IDX_W = 3;              // register index width in a bank
    localparam int CMP_IDX_W = $clog2(CMP_N);

    localparam logic [REG_IDX_W-1:0] RI_CTRL = 3'd0;
    localparam logic [REG_IDX_W-1:0] RI_IEN  = 3'd1;
    localparam logic [REG_IDX_W-1:0] RI_STAT = 3'd2;
    localparam logic [REG_IDX_W-1:0] RI_CNT  = 3'd3;
    localparam logic [REG_IDX_W-1:0] RI_CMP0 = 3'd4;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_ON_A = 2'b01,
        CLR_ON_B = 2'b10,
        CLR_ON_C = 2'b11
    } clr_sel_e;
endpackage

// File: rtl/cct_counter.sv
// Up-counter of one channel.
// Assumes: tick is already qualified by the run bit; a load has priority
// over counting; clr_hit is only meaningful together with tick.
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr_hit,
    output logic [W-1:0] cnt,
    output logic         ovf_ev
);
    localparam logic [W-1:0] TOP = '1;

    // Counter register: load, clear on match, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= clr_hit ? '0 : cnt + W'(1);
        end
    end

    // Overflow event: a plain step from the top value.
    assign ovf_ev = tick && !load && !clr_hit && (cnt == TOP);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt)); // R2
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clr_hit && !load) |=> (cnt == '0)); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_ev |=> (cnt == '0)); // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val))); // R11
endmodule

// File: rtl/cct_compare.sv
// Compare bank of one channel: per-register match events and the
// clearing decision from the clear-select field.
// Assumes: at least three compare registers, so that codes 01..11 map onto
// registers 0..2.
module cct_compare
    import cct_pkg::*;
#(
    parameter int W = 16,
    parameter int N = CMP_N
) (
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_val [N],
    input  logic [1:0]   clr_sel,
    output logic [N-1:0] match_ev,
    output logic         clr_hit
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] sel_idx;

    // One equality comparator per compare register.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_ev[g] = tick && (cnt == cmp_val[g]);
    end

    // Map clear-select code to the register it names.
    assign sel_idx = IW'(clr_sel - 2'd1);

    // Clear only when a source is chosen and that register matched.
    always_comb begin
        clr_hit = 1'b0;
        if (clr_sel != CLR_NONE) begin
            clr_hit = match_ev[sel_idx];
        end
    end
endmodule

// File: rtl/cct_flags.sv
// Status flags with read-then-write-zero clearing and interrupt gating.
// Assumes: stat_rd and stat_wr are never both high in one cycle.
module cct_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         stat_rd,
    input  logic         stat_wr,
    input  logic [N-1:0] wr_bits,
    input  logic [N-1:0] ien,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] armed;
    logic [N-1:0] clr_mask;
    logic [N-1:0] flags_nxt;

    // Next flag value: armed zero-writes clear, new events set (set wins).
    always_comb begin
        clr_mask  = stat_wr ? (armed & ~wr_bits) : '0;
        flags_nxt = (flags & ~clr_mask) | set_ev;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end

    // Arming: a read of a set flag arms it; any status write disarms all.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= '0;
        else if (stat_wr) armed <= '0;
        else if (stat_rd) armed <= (armed | flags) & flags_nxt;
        else              armed <= armed & flags_nxt;
    end

    assign irq = |(flags & ien);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((flags & $past(set_ev)) == $past(set_ev))); // R9
    AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && (armed == '0)) |=> ((flags & $past(flags)) == $past(flags))); // R8
endmodule

// File: rtl/cct_channel.sv
// One timer channel: its control, enable and compare registers, counter,
// compare bank, flags and read mux.
// Assumes: sel is high only when the bus address falls in this bank.
module cct_channel
    import cct_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [W-1:0]         wdata,
    input  logic                 run,
    input  logic                 cnt_en,
    output logic [W-1:0]         rdata,
    output logic                 irq
);
    logic              tick;
    logic              wr_hit;
    logic              rd_hit;
    logic [1:0]        clr_sel;
    logic [FLAG_N-1:0] ien;
    logic [W-1:0]      cmp_val [CMP_N];
    logic [W-1:0]      cnt;
    logic              ovf_ev;
    logic              clr_hit;
    logic [CMP_N-1:0]  match_ev;
    logic [FLAG_N-1:0] flags;
    logic              load;

    assign tick   = run && cnt_en;
    assign wr_hit = sel && wr_en;
    assign rd_hit = sel && rd_en;
    assign load   = wr_hit && (reg_idx == RI_CNT);

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_sel <= CLR_NONE;
            ien     <= '0;
        end else if (wr_hit) begin
            if (reg_idx == RI_CTRL) clr_sel <= wdata[1:0];
            if (reg_idx == RI_IEN)  ien     <= wdata[FLAG_N-1:0];
        end
    end

    // Compare registers, reset to all ones.
    always_ff @(posedge clk) begin
        for (int k = 0; k < CMP_N; k++) begin
            if (!rst_n) begin
                cmp_val[k] <= '1;
            end else if (wr_hit && (reg_idx == REG_IDX_W'(int'(RI_CMP0) + k))) begin
                cmp_val[k] <= wdata;
            end
        end
    end

    cct_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .load_val (wdata),
        .clr_hit  (clr_hit),
        .cnt      (cnt),
        .ovf_ev   (ovf_ev)
    );

    cct_compare #(.W(W), .N(CMP_N)) u_compare (
        .tick     (tick),
        .cnt      (cnt),
        .cmp_val  (cmp_val),
        .clr_sel  (clr_sel),
        .match_ev (match_ev),
        .clr_hit  (clr_hit)
    );

    cct_flags #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  ({ovf_ev, match_ev}),
        .stat_rd (rd_hit && (reg_idx == RI_STAT)),
        .stat_wr (wr_hit && (reg_idx == RI_STAT)),
        .wr_bits (wdata[FLAG_N-1:0]),
        .ien     (ien),
        .flags   (flags),
        .irq     (irq)
    );

    // Register read mux.
    always_comb begin
        case (reg_idx)
            RI_CTRL: rdata = W'(clr_sel);
            RI_IEN:  rdata = W'(ien);
            RI_STAT: rdata = W'(flags);
            RI_CNT:  rdata = cnt;
            default: rdata = cmp_val[reg_idx[CMP_IDX_W-1:0]];
        endcase
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_hit && (reg_idx == RI_STAT || reg_idx == RI_IEN))) |=> irq); // R10
    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((flags & ~$past(flags)) == '0)); // R5
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !clr_hit) |=> (cnt == $past(cnt) + W'(1))); // R6
endmodule

// File: rtl/cct_timer.sv
// Dual-channel compare-clear timer top: bank decode, shared run register,
// channel array and read-data selection.
// Assumes: bus_rd and bus_wr are not asserted together.
module cct_timer
    import cct_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    localparam int BANK_W = $clog2(NUM_CH + 1),
    localparam int ADDR_W = BANK_W + REG_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              cnt_en,
    output logic [NUM_CH-1:0] irq
);
    logic [BANK_W-1:0]    bank;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [NUM_CH-1:0]    run;
    logic [CNT_W-1:0]     ch_rdata [NUM_CH];
    logic                 run_wr;

    assign bank    = bus_addr[ADDR_W-1:REG_IDX_W];
    assign reg_idx = bus_addr[REG_IDX_W-1:0];
    assign run_wr  = bus_wr && (bank == '0) && (reg_idx == '0);

    // Shared run register, one bit per channel.
    always_ff @(posedge clk) begin
        if (!rst_n)      run <= '0;
        else if (run_wr) run <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cct_channel #(.W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (bank == BANK_W'(g + 1)),
            .wr_en   (bus_wr),
            .rd_en   (bus_rd),
            .reg_idx (reg_idx),
            .wdata   (bus_wdata),
            .run     (run[g]),
            .cnt_en  (cnt_en),
            .rdata   (ch_rdata[g]),
            .irq     (irq[g])
        );
    end

    // Read-data selection across the global bank and channel banks.
    always_comb begin
        bus_rdata = '0;
        if (bank == '0 && reg_idx == '0) bus_rdata = CNT_W'(run);
        for (int k = 0; k < NUM_CH; k++) begin
            if (bank == BANK_W'(k + 1)) bus_rdata = ch_rdata[k];
        end
    end

    AST_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        run_wr |=> (run == $past(bus_wdata[NUM_CH-1:0]))); // R12
    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_wr |=> $stable(run)); // R2
endmodule

// File: tb/cct_timer_test.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module cct_timer_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] A_RUN   = 5'd0;
    localparam logic [4:0] A_CTRL0 = 5'd8;
    localparam logic [4:0] A_IEN0  = 5'd9;
    localparam logic [4:0] A_STAT0 = 5'd10;
    localparam logic [4:0] A_CNT0  = 5'd11;
    localparam logic [4:0] A_CA0   = 5'd12;
    localparam logic [4:0] A_CB0   = 5'd13;
    localparam logic [4:0] A_CC0   = 5'd14;
    localparam logic [4:0] A_CD0   = 5'd15;
    localparam logic [4:0] A_CTRL1 = 5'd16;
    localparam logic [4:0] A_IEN1  = 5'd17;
    localparam logic [4:0] A_STAT1 = 5'd18;
    localparam logic [4:0] A_CNT1  = 5'd19;
    localparam logic [4:0] A_CA1   = 5'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cnt_en = 1'b0;
    logic [1:0]  irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit chk_stb = 1'b0;

    logic [15:0] exp_q [$];
    bit          kind_q [$];
    string       tag_q [$];

    cct_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_en    (cnt_en),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic write_with_tick(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; cnt_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_en = 1'b1;
        end
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(tag);
        chk_stb = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; chk_stb = 1'b0;
    endtask

    task automatic expect_irq(input logic [1:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back({14'd0, e}); kind_q.push_back(1'b1); tag_q.push_back(tag);
        chk_stb = 1'b1;
        @(negedge clk);
        chk_stb = 1'b0;
    endtask

    // Monitor: sample a quarter period after the falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            if (chk_stb && exp_q.size() > 0) begin
                logic [15:0] e;
                logic [15:0] act;
                bit          k;
                string       t;
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                t = tag_q.pop_front();
                act = k ? {14'd0, irq} : bus_rdata;
                checks++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_rd(A_CNT0, 16'h0000, "R1 cnt0");
        expect_rd(A_CNT1, 16'h0000, "R1 cnt1");
        expect_rd(A_CTRL0, 16'h0000, "R1 ctrl0");
        expect_rd(A_STAT0, 16'h0000, "R1 stat0");
        expect_rd(A_STAT1, 16'h0000, "R1 stat1");
        expect_rd(A_RUN, 16'h0000, "R1 run");
        expect_rd(A_CD0, 16'hFFFF, "R1 compare D reset");
        expect_irq(2'b00, "R1 irq");

        // R2 counting gated by run bits
        tick(3);
        expect_rd(A_CNT0, 16'd0, "R2 stopped");
        bus_write(A_RUN, 16'h0001);
        expect_rd(A_RUN, 16'h0001, "R12 run readback");
        tick(3);
        expect_rd(A_CNT0, 16'd3, "R2 ch0 counts");
        expect_rd(A_CNT1, 16'd0, "R2 ch1 idle");
        bus_write(A_RUN, 16'h0003);
        tick(2);
        expect_rd(A_CNT0, 16'd5, "R2 ch0 both");
        expect_rd(A_CNT1, 16'd2, "R2 ch1 both");
        bus_write(A_RUN, 16'h0001);

        // R3 overflow, R10 enable
        bus_write(A_CNT0, 16'hFFFE);
        expect_rd(A_CNT0, 16'hFFFE, "R11 counter write");
        tick(1);
        expect_rd(A_CNT0, 16'hFFFF, "R3 top");
        tick(1);
        expect_rd(A_CNT0, 16'h0000, "R3 wrap");
        expect_irq(2'b00, "R10 disabled");
        bus_write(A_IEN0, 16'h0010);
        expect_irq(2'b01, "R10 overflow irq");

        // R8 clear protocol
        bus_write(A_STAT0, 16'h0000);
        expect_irq(2'b01, "R8 unread zero write");
        expect_rd(A_STAT0, 16'h001F, "R3 overflow plus D..A at 0xFFFF");
        bus_write(A_STAT0, 16'h000F);
        expect_irq(2'b00, "R8 overflow cleared");
        expect_rd(A_STAT0, 16'h000F, "R8 write one keeps");
        bus_write(A_STAT0, 16'h0000);
        expect_rd(A_STAT0, 16'h0000, "R8 all cleared");

        // R5 match flags without clearing
        bus_write(A_CA0, 16'd100);
        bus_write(A_CB0, 16'd5);
        bus_write(A_CC0, 16'd200);
        bus_write(A_CD0, 16'd7);
        tick(5);
        expect_rd(A_STAT0, 16'h0000, "R5 no flag before count at value");
        tick(1);
        expect_rd(A_CNT0, 16'd6, "R5 free counter passes match");
        expect_rd(A_STAT0, 16'h0002, "R5 flag B");
        tick(2);
        expect_rd(A_STAT0, 16'h000A, "R5 flags B and D");
        bus_write(A_STAT0, 16'h0000);
        expect_rd(A_STAT0, 16'h0000, "R8 cleared B D");

        // R4 periodic on B, A, C
        bus_write(A_CTRL0, 16'h0002);
        expect_rd(A_CTRL0, 16'h0002, "R12 ctrl readback");
        bus_write(A_CNT0, 16'd0);
        tick(6);
        expect_rd(A_CNT0, 16'd0, "R4 clear on B");
        expect_rd(A_STAT0, 16'h0002, "R4 flag B");
        tick(2);
        expect_rd(A_CNT0, 16'd2, "R4 resumes from zero");
        bus_write(A_STAT0, 16'h0000);
        bus_write(A_CTRL0, 16'h0001);
        bus_write(A_CNT0, 16'd98);
        tick(3);
        expect_rd(A_CNT0, 16'd0, "R4 clear on A");
        expect_rd(A_STAT0, 16'h0001, "R4 flag A");
        bus_write(A_STAT0, 16'h0000);
        bus_write(A_CTRL0, 16'h0003);
        bus_write(A_CNT0, 16'd199);
        tick(2);
        expect_rd(A_CNT0, 16'd0, "R4 clear on C");
        expect_rd(A_STAT0, 16'h0004, "R4 flag C");
        bus_write(A_STAT0, 16'h0000);

        // R6 D never clears
        bus_write(A_CNT0, 16'd6);
        tick(2);
        expect_rd(A_CNT0, 16'd8, "R6 D no clear");
        expect_rd(A_STAT0, 16'h0008, "R6 flag D");
        bus_write(A_STAT0, 16'h0000);

        // R7 clearing match at top value
        bus_write(A_CC0, 16'hFFFF);
        bus_write(A_CNT0, 16'hFFFF);
        tick(1);
        expect_rd(A_CNT0, 16'h0000, "R7 cleared");
        expect_rd(A_STAT0, 16'h0004, "R7 no overflow flag");
        expect_irq(2'b00, "R10 C not enabled");
        bus_write(A_IEN0, 16'h0004);
        expect_irq(2'b01, "R10 C enabled");

        // Channel 1 periodic on A
        bus_write(A_CA1, 16'd3);
        bus_write(A_CTRL1, 16'h0001);
        bus_write(A_IEN1, 16'h0001);
        bus_write(A_RUN, 16'h0002);
        tick(2);
        expect_rd(A_CNT1, 16'd0, "R4 ch1 clear on A");
        expect_rd(A_STAT1, 16'h0001, "R5 ch1 flag A");
        expect_irq(2'b11, "R10 both channels");

        // R9 set wins over clear
        bus_write(A_RUN, 16'h0001);
        bus_write(A_CNT0, 16'hFFFF);
        expect_rd(A_STAT0, 16'h0004, "R9 armed read");
        write_with_tick(A_STAT0, 16'h0000);
        expect_rd(A_CNT0, 16'h0000, "R9 counter cleared");
        expect_rd(A_STAT0, 16'h0004, "R9 flag kept");
        expect_irq(2'b11, "R9 irq kept");

        // R11 write beats count
        write_with_tick(A_CNT0, 16'h1234);
        expect_rd(A_CNT0, 16'h1234, "R11 write priority");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule